// File: doc/BRIEF.md
# Configurable UART Serial Transmitter Framer

This block turns parallel characters into an asynchronous serial frame on a single transmit line. Software-side logic writes a character into a holding register. As soon as the shift stage is idle, the character moves into it. The block then sends, in order:

- a low start bit;
- 5 to 8 data bits, least significant first;
- an optional parity bit;
- one, one and a half or two high stop bits.

Each bit lasts 16 pulses of a baud tick input, which runs at sixteen times the bit rate. The baud divider sits outside this block.

The frame format comes from line-control inputs:

- word length;
- stop-bit control;
- parity enable;
- even select;
- stick parity.

The block captures these inputs when a character moves into the shift stage, so the frame in progress keeps the format it started with. A separate break input forces the line low for as long as it is held. Two flags report progress:

- holding-empty tells the writer when a new character may be loaded;
- transmitter-empty shows that the line has gone fully idle.

Top module: `uart_tx_framer`

## Requirements
- R1: Word length code `wordLen` 0, 1, 2 and 3 selects 5, 6, 7 and 8 data bits. Data bits are sent least significant bit first, and bits above the selected length are not sent.
- R2: The line idles high and each frame begins with a low start bit. Every start, data and parity bit lasts exactly 16 baud ticks. Without ticks a frame in progress does not advance.
- R3: With `stopCtl` = 0, the frame ends with one high stop bit of 16 ticks.
- R4: With `stopCtl` = 1 and `wordLen` = 0 (5 bits), the stop time is 24 ticks (one and a half bits).
- R5: With `stopCtl` = 1 and `wordLen` of 1 to 3, the stop time is 32 ticks (two bits).
- R6: When `parityEn` = 1 and `stickPar` = 0, one parity bit follows the data. It is chosen so that the number of ones in the sent data bits plus the parity bit is even when `evenSel` = 1, or odd when `evenSel` = 0. With `parityEn` = 0 no parity bit is sent.
- R7: When `parityEn` = 1 and `stickPar` = 1, the parity bit is the fixed level NOT `evenSel`.
- R8: While `breakEn` = 1, `txOut` is 0. Framing keeps running underneath, so the frame still ends at its normal time.
- R9: `holdEmpty` is 1 after reset. It is 0 in the cycle after a `loadValid` pulse, and it returns to 1 when the character moves into the shift stage.
- R10: `txEmpty` is 1 only when the holding register is empty and no frame is in progress. It stays 0 between back-to-back frames while a second character is waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baudTick | input | 1 | One-cycle pulse at sixteen times the bit rate |
| loadValid | input | 1 | Writes `loadData` into the holding register (overwrites any waiting character) |
| loadData | input | 8 | Character to send |
| wordLen | input | 2 | Data-bit count select (0..3 gives 5..8 bits) |
| stopCtl | input | 1 | 0 gives one stop bit; 1 gives 1.5 stop bits for 5-bit characters and 2 stop bits otherwise |
| parityEn | input | 1 | Inserts a parity bit after the data |
| evenSel | input | 1 | 1 selects even parity, 0 selects odd parity |
| stickPar | input | 1 | Sends the fixed parity level NOT `evenSel` |
| breakEn | input | 1 | Forces the line low |
| txOut | output | 1 | Serial transmit line |
| holdEmpty | output | 1 | Holding register can accept a character |
| txEmpty | output | 1 | Holding register and shift stage both idle |

## Verification
A wrong bit counter or a wrong length latch shows up at the line within one bit time. The character gains or loses a data bit, and the bench sees this as a wrong level at a mid-bit sample or a frame end that moves by 16 ticks. A wrong stop-time choice moves the rise of `txEmpty` by 8 or 16 ticks. A wrong parity reduction or masking flips a single mid-bit sample. A lost or duplicated hand-over between the holding register and the shift stage shows on the next clock as a stuck `holdEmpty`, or as a `txEmpty` pulse between back-to-back frames.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PARITY,
    PH_STOP
  } txPhase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic     xfer;   // holding register moves into shift stage
    logic     shift;  // advance to next data bit
    txPhase_t phase;  // current frame section
  } txStrobe_t;

endpackage

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_MAX      = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baudTick,
  input  logic       holdFull,
  input  logic [1:0] wordLen,
  input  logic       stopCtl,
  input  logic       parityEn,
  output txStrobe_t  strobe
);

  localparam int TCNT_W   = $clog2(2 * TICKS_PER_BIT + 1);
  localparam int BCNT_W   = $clog2(DATA_MAX);
  localparam int MIN_LAST = DATA_MAX - 4;
  localparam logic [TCNT_W-1:0] ONE_STOP   = TCNT_W'(TICKS_PER_BIT);
  localparam logic [TCNT_W-1:0] HALF_STOP  = TCNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
  localparam logic [TCNT_W-1:0] TWO_STOP   = TCNT_W'(2 * TICKS_PER_BIT);

  txPhase_t            phase;
  logic [TCNT_W-1:0]   tickCnt;
  logic [TCNT_W-1:0]   stopTicks;
  logic [TCNT_W-1:0]   phaseLen;
  logic [BCNT_W-1:0]   bitCnt;
  logic [BCNT_W-1:0]   lastIdx;
  logic                parOn;
  logic                xfer;
  logic                phaseDone;

  assign xfer      = (phase == PH_IDLE) && holdFull;
  assign phaseLen  = (phase == PH_STOP) ? stopTicks : ONE_STOP;
  assign phaseDone = baudTick && (phase != PH_IDLE) && (tickCnt == phaseLen - TCNT_W'(1));

  assign strobe.xfer  = xfer;
  assign strobe.shift = phaseDone && (phase == PH_DATA);
  assign strobe.phase = phase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      tickCnt   <= '0;
      bitCnt    <= '0;
      lastIdx   <= '0;
      stopTicks <= ONE_STOP;
      parOn     <= 1'b0;
    end else if (xfer) begin
      phase     <= PH_START;
      tickCnt   <= '0;
      bitCnt    <= '0;
      lastIdx   <= BCNT_W'(MIN_LAST) + BCNT_W'(wordLen);
      parOn     <= parityEn;
      if (!stopCtl)             stopTicks <= ONE_STOP;
      else if (wordLen == 2'd0) stopTicks <= HALF_STOP;
      else                      stopTicks <= TWO_STOP;
    end else if (baudTick && (phase != PH_IDLE)) begin
      if (phaseDone) begin
        tickCnt <= '0;
        case (phase)
          PH_START:  phase <= PH_DATA;
          PH_DATA: begin
            if (bitCnt == lastIdx) phase <= parOn ? PH_PARITY : PH_STOP;
            else                   bitCnt <= bitCnt + 1'b1;
          end
          PH_PARITY: phase <= PH_STOP;
          default:   phase <= PH_IDLE;
        endcase
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/uart_tx_data.sv
module uart_tx_data
  import uart_tx_pkg::*;
#(
  parameter int DATA_MAX = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadValid,
  input  logic [DATA_MAX-1:0] loadData,
  input  logic [1:0]          wordLen,
  input  logic                evenSel,
  input  logic                stickPar,
  input  logic                breakEn,
  input  txStrobe_t           strobe,
  output logic                holdFull,
  output logic                txOut
);

  localparam int MIN_LAST = DATA_MAX - 4;

  logic [DATA_MAX-1:0] holdReg;
  logic [DATA_MAX-1:0] shiftReg;
  logic [DATA_MAX-1:0] dataMask;
  logic                parBit;
  logic                parNext;
  logic                onesOdd;
  logic                lineBit;

  always_comb begin
    for (int i = 0; i < DATA_MAX; i++) begin
      dataMask[i] = (i <= MIN_LAST + int'(wordLen));
    end
  end

  assign onesOdd = ^(holdReg & dataMask);
  assign parNext = stickPar ? ~evenSel : (evenSel ? onesOdd : ~onesOdd);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      holdFull <= 1'b0;
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (loadValid) begin
        holdReg  <= loadData;
        holdFull <= 1'b1;
      end else if (strobe.xfer) begin
        holdFull <= 1'b0;
      end
      if (strobe.xfer) begin
        shiftReg <= holdReg;
        parBit   <= parNext;
      end else if (strobe.shift) begin
        shiftReg <= shiftReg >> 1;
      end
    end
  end

  always_comb begin
    case (strobe.phase)
      PH_START:  lineBit = 1'b0;
      PH_DATA:   lineBit = shiftReg[0];
      PH_PARITY: lineBit = parBit;
      default:   lineBit = 1'b1;
    endcase
  end

  assign txOut = lineBit && !breakEn;

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int TICKS_PER_BIT = 16,
  parameter int DATA_MAX      = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                baudTick,
  input  logic                loadValid,
  input  logic [DATA_MAX-1:0] loadData,
  input  logic [1:0]          wordLen,
  input  logic                stopCtl,
  input  logic                parityEn,
  input  logic                evenSel,
  input  logic                stickPar,
  input  logic                breakEn,
  output logic                txOut,
  output logic                holdEmpty,
  output logic                txEmpty
);

  txStrobe_t ctlStrobe;
  logic      holdFull;

  uart_tx_ctrl #(
    .TICKS_PER_BIT(TICKS_PER_BIT),
    .DATA_MAX     (DATA_MAX)
  ) i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .baudTick(baudTick),
    .holdFull(holdFull),
    .wordLen (wordLen),
    .stopCtl (stopCtl),
    .parityEn(parityEn),
    .strobe  (ctlStrobe)
  );

  uart_tx_data #(
    .DATA_MAX(DATA_MAX)
  ) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .loadValid(loadValid),
    .loadData (loadData),
    .wordLen  (wordLen),
    .evenSel  (evenSel),
    .stickPar (stickPar),
    .breakEn  (breakEn),
    .strobe   (ctlStrobe),
    .holdFull (holdFull),
    .txOut    (txOut)
  );

  assign holdEmpty = !holdFull;
  assign txEmpty   = (ctlStrobe.phase == PH_IDLE) && !holdFull;

endmodule

// File: rtl/uart_tx_framer_chk.sv
module uart_tx_framer_chk
  import uart_tx_pkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      baudTick,
  input logic      loadValid,
  input logic      breakEn,
  input logic      txOut,
  input logic      holdEmpty,
  input logic      txEmpty,
  input txStrobe_t ctlStrobe
);

  p_idle_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !breakEn) |-> txOut);

  p_hold_without_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStrobe.phase != PH_IDLE && !baudTick) |=> $stable(ctlStrobe.phase));

  p_stop_high_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStrobe.phase == PH_STOP && !breakEn) |-> txOut);

  p_shift_stays_framed_r1: assert property (@(posedge clk) disable iff (!rstN)
    ctlStrobe.shift |=> (ctlStrobe.phase == PH_DATA || ctlStrobe.phase == PH_PARITY ||
                         ctlStrobe.phase == PH_STOP));

  p_break_low_r8: assert property (@(posedge clk) disable iff (!rstN)
    breakEn |-> !txOut);

  p_load_fills_r9: assert property (@(posedge clk) disable iff (!rstN)
    loadValid |=> !holdEmpty);

  p_xfer_frees_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctlStrobe.xfer && !loadValid) |=> (holdEmpty && !txEmpty));

  p_empty_needs_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    txEmpty |-> holdEmpty);

endmodule

bind uart_tx_framer uart_tx_framer_chk i_chk (.*);

// File: tb/test_uart_tx_framer.sv
module test_uart_tx_framer;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       baudTick = 1'b0;
  logic       loadValid = 1'b0;
  logic [7:0] loadData = '0;
  logic [1:0] wordLen = '0;
  logic       stopCtl = 1'b0;
  logic       parityEn = 1'b0;
  logic       evenSel = 1'b0;
  logic       stickPar = 1'b0;
  logic       breakEn = 1'b0;
  logic       txOut, holdEmpty, txEmpty;

  int errCount = 0;
  int checkCount = 0;
  int tickDiv = 1;
  bit tickEn = 1'b1;

  uart_tx_framer i_uart_tx_framer (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .loadValid(loadValid),
    .loadData(loadData), .wordLen(wordLen), .stopCtl(stopCtl), .parityEn(parityEn),
    .evenSel(evenSel), .stickPar(stickPar), .breakEn(breakEn),
    .txOut(txOut), .holdEmpty(holdEmpty), .txEmpty(txEmpty)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // Baud tick stimulus, driven at falling edges
  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (!tickEn) begin
        baudTick = 1'b0;
        cnt = 0;
      end else if (cnt >= tickDiv - 1) begin
        baudTick = 1'b1;
        cnt = 0;
      end else begin
        baudTick = 1'b0;
        cnt++;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checkCount++;
    if (!ok) begin
      errCount++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setFormat(input logic [1:0] wl, input logic sc, input logic pe,
                           input logic es, input logic sp);
    @(negedge clk);
    wordLen = wl; stopCtl = sc; parityEn = pe; evenSel = es; stickPar = sp;
  endtask

  task automatic sendChar(input logic [7:0] d);
    @(negedge clk);
    loadValid = 1'b1;
    loadData = d;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic waitStart();
    int guard = 0;
    while (txOut !== 1'b0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Samples a frame at bit centres; optionally measures total frame time
  task automatic expectFrame(input logic [7:0] d, input int nbits, input bit hasPar,
                             input bit parVal, input int stopTicks, input bit measure,
                             input string dreq, input string preq, input string sreq);
    int elapsed;
    int expTotal;
    int diff;
    waitStart();
    repeat (8 * tickDiv) @(negedge clk);
    check(txOut == 1'b0, "R2", "start bit level", int'(txOut), 0);
    for (int k = 0; k < nbits; k++) begin
      repeat (16 * tickDiv) @(negedge clk);
      check(txOut == d[k], dreq, $sformatf("data bit %0d", k), int'(txOut), int'(d[k]));
    end
    if (hasPar) begin
      repeat (16 * tickDiv) @(negedge clk);
      check(txOut == parVal, preq, "parity bit", int'(txOut), int'(parVal));
    end
    repeat (16 * tickDiv) @(negedge clk);
    check(txOut == 1'b1, sreq, "stop level", int'(txOut), 1);
    if (measure) begin
      elapsed = 8 * tickDiv + 16 * tickDiv * (nbits + int'(hasPar) + 1);
      while (!txEmpty && elapsed < 20000) begin
        @(negedge clk);
        elapsed++;
      end
      expTotal = (16 * (1 + nbits + int'(hasPar)) + stopTicks) * tickDiv;
      diff = elapsed - expTotal;
      if (diff < 0) diff = -diff;
      check(diff <= tickDiv + 1, sreq, "frame length in clocks", elapsed, expTotal);
    end
  endtask

  task automatic t_reset();
    check(txOut == 1'b1, "R2", "idle line after reset", int'(txOut), 1);
    check(holdEmpty == 1'b1, "R9", "holdEmpty after reset", int'(holdEmpty), 1);
    check(txEmpty == 1'b1, "R10", "txEmpty after reset", int'(txEmpty), 1);
  endtask

  task automatic t_lengths();
    logic [7:0] pats [4] = '{8'hD5, 8'h2B, 8'h9E, 8'h6C};
    for (int wl = 0; wl < 4; wl++) begin
      setFormat(2'(wl), 1'b0, 1'b0, 1'b0, 1'b0);
      sendChar(pats[wl]);
      expectFrame(pats[wl], 5 + wl, 1'b0, 1'b0, 16, 1'b1, "R1", "R6", "R3");
    end
  endtask

  task automatic t_stops();
    setFormat(2'd0, 1'b1, 1'b0, 1'b0, 1'b0);
    sendChar(8'h1B);
    expectFrame(8'h1B, 5, 1'b0, 1'b0, 24, 1'b1, "R1", "R6", "R4");
    setFormat(2'd3, 1'b1, 1'b0, 1'b0, 1'b0);
    sendChar(8'hA5);
    expectFrame(8'hA5, 8, 1'b0, 1'b0, 32, 1'b1, "R1", "R6", "R5");
    setFormat(2'd1, 1'b1, 1'b0, 1'b0, 1'b0);
    sendChar(8'h33);
    expectFrame(8'h33, 6, 1'b0, 1'b0, 32, 1'b1, "R1", "R6", "R5");
  endtask

  task automatic t_parity();
    // 0xA7 has five ones: even parity bit 1, odd parity bit 0
    setFormat(2'd3, 1'b0, 1'b1, 1'b1, 1'b0);
    sendChar(8'hA7);
    expectFrame(8'hA7, 8, 1'b1, 1'b1, 16, 1'b1, "R1", "R6", "R6");
    setFormat(2'd3, 1'b0, 1'b1, 1'b0, 1'b0);
    sendChar(8'hA7);
    expectFrame(8'hA7, 8, 1'b1, 1'b0, 16, 1'b1, "R1", "R6", "R6");
    // 7-bit: bit 7 not sent, sent ones = 2, even parity bit 0
    setFormat(2'd2, 1'b0, 1'b1, 1'b1, 1'b0);
    sendChar(8'h83);
    expectFrame(8'h83, 7, 1'b1, 1'b0, 16, 1'b1, "R1", "R6", "R6");
  endtask

  task automatic t_stick();
    setFormat(2'd3, 1'b0, 1'b1, 1'b0, 1'b1);
    sendChar(8'h01);
    expectFrame(8'h01, 8, 1'b1, 1'b1, 16, 1'b1, "R1", "R7", "R7");
    setFormat(2'd3, 1'b0, 1'b1, 1'b1, 1'b1);
    sendChar(8'h01);
    expectFrame(8'h01, 8, 1'b1, 1'b0, 16, 1'b1, "R1", "R7", "R7");
  endtask

  task automatic t_pacing();
    int guard;
    tickDiv = 3;
    setFormat(2'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    sendChar(8'h2D);
    expectFrame(8'h2D, 6, 1'b0, 1'b0, 16, 1'b1, "R2", "R6", "R2");
    tickDiv = 1;
    // No ticks: frame must freeze in start bit
    @(negedge clk);
    tickEn = 1'b0;
    setFormat(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    sendChar(8'h1F);
    waitStart();
    repeat (100) @(negedge clk);
    check(txOut == 1'b0, "R2", "line frozen low without ticks", int'(txOut), 0);
    check(txEmpty == 1'b0, "R2", "still busy without ticks", int'(txEmpty), 0);
    tickEn = 1'b1;
    guard = 0;
    while (!txEmpty && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    check((guard >= 110) && (guard <= 114), "R2", "clocks after ticks resume", guard, 112);
  endtask

  task automatic t_break();
    int elapsed;
    breakEn = 1'b1;
    @(negedge clk);
    check(txOut == 1'b0, "R8", "break on idle line", int'(txOut), 0);
    breakEn = 1'b0;
    @(negedge clk);
    check(txOut == 1'b1, "R8", "line after break release", int'(txOut), 1);
    setFormat(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    sendChar(8'hFF);
    waitStart();
    elapsed = 0;
    repeat (24) @(negedge clk);
    elapsed += 24;
    breakEn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      repeat (16) @(negedge clk);
      elapsed += 16;
      check(txOut == 1'b0, "R8", "break over data one", int'(txOut), 0);
    end
    breakEn = 1'b0;
    repeat (16) @(negedge clk);
    elapsed += 16;
    check(txOut == 1'b1, "R8", "data resumes after break", int'(txOut), 1);
    while (!txEmpty && elapsed < 5000) begin
      @(negedge clk);
      elapsed++;
    end
    check((elapsed >= 158) && (elapsed <= 162), "R8", "frame end unchanged by break",
          elapsed, 160);
  endtask

  task automatic t_holding();
    bit sawEmpty = 1'b0;
    int guard = 0;
    setFormat(2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    loadValid = 1'b1;
    loadData = 8'h5A;
    @(negedge clk);
    loadValid = 1'b0;
    check(holdEmpty == 1'b0, "R9", "holdEmpty after load", int'(holdEmpty), 0);
    check(txEmpty == 1'b0, "R10", "txEmpty after load", int'(txEmpty), 0);
    @(negedge clk);
    check(holdEmpty == 1'b1, "R9", "holdEmpty after transfer", int'(holdEmpty), 1);
    check(txEmpty == 1'b0, "R10", "txEmpty while shifting", int'(txEmpty), 0);
    fork
      expectFrame(8'h5A, 8, 1'b0, 1'b0, 16, 1'b0, "R1", "R6", "R3");
      begin
        repeat (40) @(negedge clk);
        sendChar(8'hC3);
        check(holdEmpty == 1'b0, "R9", "holdEmpty with waiting char", int'(holdEmpty), 0);
      end
    join
    while (!holdEmpty && guard < 5000) begin
      if (txEmpty) sawEmpty = 1'b1;
      @(negedge clk);
      guard++;
    end
    check(!sawEmpty, "R10", "no txEmpty between frames", int'(sawEmpty), 0);
    check(txOut == 1'b0, "R9", "second frame starts at transfer", int'(txOut), 0);
    expectFrame(8'hC3, 8, 1'b0, 1'b0, 16, 1'b1, "R1", "R6", "R3");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errCount++;
    $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errCount, checkCount + 1);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_stops();
    t_parity();
    t_stick();
    t_pacing();
    t_break();
    t_holding();
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errCount, checkCount);
    $finish;
  end

endmodule